// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Engine

This block forms the signed integer dot product of a vector of 8-bit signed activations with a row of ternary weights, where each weight is -1, 0 or +1. It has no multiplier. Each weight is a 2-bit code that makes its lane do one of three things: pass the activation on unchanged, pass on its negation, or contribute nothing. A zero weight switches its lane off completely.

A configurable number of lanes is presented every cycle. Their contributions are reduced by a combinational adder tree and added into a registered accumulator. The row may span any number of beats up to the configured maximum length, and a last flag on the final beat closes it. One cycle after that beat, the full signed sum appears together with a one-cycle valid pulse and the number of nonzero weights in the row. The accumulator then starts again from zero for the next row.

Scaling of the result by weight or activation factors is done downstream.

Top module: `ternary_dot`

## Requirements
- R1: Lane i takes its activation from act_i[8*i+7:8*i] and its weight code from wgt_i[2*i+1:2*i]. Code 2'b01 adds the activation to the row sum.
- R2: Weight code 2'b11 subtracts the lane's activation from the row sum.
- R3: Weight codes 2'b00 and 2'b10 leave the row sum unchanged, whatever the activation is.
- R4: The sums of all accepted beats of a row are accumulated. res_valid_o rises in the cycle after the beat that has in_last_i set and stays high for exactly one cycle. res_o holds its value until the next result.
- R5: After a row closes, the next row starts from zero, including when two closing beats come back to back.
- R6: The accumulator is ACT_W + clog2(MAX_LEN) + 1 bits wide. A row of MAX_LEN elements at the extremes (-128 with weight -1, or -128 with weight +1) gives the exact values +32768 and -32768 at the defaults.
- R7: nz_cnt_o, presented together with res_o, holds the number of weights in the row whose code is 2'b01 or 2'b11.
- R8: A cycle with in_valid_i low changes neither the sum nor the count, and produces no result even if in_last_i is high.
- R9: While reset is active and just after it, res_valid_o, res_o and nz_cnt_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | The beat on the inputs is accepted this cycle |
| in_last_i | input | 1 | This beat closes the row |
| act_i | input | LANES*ACT_W | Packed signed activations, lane 0 in the low bits |
| wgt_i | input | 2*LANES | Packed ternary weight codes, lane 0 in the low bits |
| res_valid_o | output | 1 | One-cycle pulse: res_o and nz_cnt_o hold a new row result |
| res_o | output | ACC_W | Signed dot product of the closed row |
| nz_cnt_o | output | NZ_W | Number of nonzero weights in the closed row |

## Verification
Single-beat rows with every lane set to add, every lane set to subtract, every lane set to each of the two skip codes, and a mix of all four codes separate the add, negate and gate paths from one another. Multi-beat rows, with an idle beat inserted that has the last flag set, show whether partial sums and counts carry correctly and whether unaccepted beats are kept out. Full-length rows of -128 against all -1 and all +1 weights reach both ends of the accumulator range. Closing beats sent back to back show that each row starts clean after the previous one.

// File: rtl/ternary_pkg.sv
package ternary_pkg;
  typedef enum logic [1:0] {
    WC_SKIP = 2'b00,
    WC_ADD  = 2'b01,
    WC_RSV  = 2'b10,
    WC_SUB  = 2'b11
  } wcode_e;

  function automatic logic is_active(input logic [1:0] code);
    return (code == WC_ADD) || (code == WC_SUB);
  endfunction
endpackage

// File: rtl/ternary_lane.sv
module ternary_lane
  import ternary_pkg::*;
#(
  parameter int ACT_W = 8
) (
  input  logic [ACT_W-1:0] act_i,
  input  logic [1:0]       code_i,
  output logic [ACT_W:0]   contrib_o,
  output logic             nz_o
);
  logic signed [ACT_W:0] act_ext;

  assign act_ext = {act_i[ACT_W-1], act_i};

  always_comb begin
    unique case (wcode_e'(code_i))
      WC_ADD:  contrib_o = act_ext;
      WC_SUB:  contrib_o = -act_ext;
      default: contrib_o = '0;
    endcase
  end

  assign nz_o = is_active(code_i);
endmodule

// File: rtl/ternary_tree.sv
module ternary_tree #(
  parameter int LANES = 8,
  parameter int IN_W  = 9,
  localparam int LVL   = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int PAD   = 1 << LVL,
  localparam int OUT_W = IN_W + LVL
) (
  input  logic [LANES*IN_W-1:0] leaf_i,
  output logic [OUT_W-1:0]      sum_o
);
  // heap layout: node 0 is root, leaves at PAD-1 .. 2*PAD-2
  logic signed [OUT_W-1:0] node [2*PAD-1];

  for (genvar i = 0; i < PAD; i++) begin : g_leaf
    if (i < LANES) begin : g_real
      assign node[PAD-1+i] = OUT_W'($signed(leaf_i[i*IN_W +: IN_W]));
    end else begin : g_pad
      assign node[PAD-1+i] = '0;
    end
  end

  for (genvar n = 0; n < PAD-1; n++) begin : g_node
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/ternary_acc.sv
module ternary_acc #(
  parameter int SUM_W   = 12,
  parameter int ACC_W   = 17,
  parameter int BNZ_W   = 4,
  parameter int NZ_W    = 9,
  parameter int MAX_LEN = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_valid_i,
  input  logic             beat_last_i,
  input  logic [SUM_W-1:0] beat_sum_i,
  input  logic [BNZ_W-1:0] beat_nz_i,
  output logic             res_valid_o,
  output logic [ACC_W-1:0] res_o,
  output logic [NZ_W-1:0]  nz_cnt_o
);
  logic signed [ACC_W-1:0] acc_q, acc_nxt, sum_ext;
  logic [NZ_W-1:0]         nz_row_q, nz_nxt;

  assign sum_ext = ACC_W'($signed(beat_sum_i));
  assign acc_nxt = acc_q + sum_ext;
  assign nz_nxt  = nz_row_q + NZ_W'(beat_nz_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      nz_row_q    <= '0;
      res_o       <= '0;
      nz_cnt_o    <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      if (beat_valid_i) begin
        if (beat_last_i) begin
          res_o       <= acc_nxt;
          nz_cnt_o    <= nz_nxt;
          res_valid_o <= 1'b1;
          acc_q       <= '0;
          nz_row_q    <= '0;
        end else begin
          acc_q    <= acc_nxt;
          nz_row_q <= nz_nxt;
        end
      end
    end
  end

  // one extra bit to detect wrap of the accumulator add
  logic signed [ACC_W:0] wide_sum;
  assign wide_sum = {acc_q[ACC_W-1], acc_q} + {sum_ext[ACC_W-1], sum_ext};

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_i |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));

  p_pulse_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_last_i) |=> res_valid_o);

  p_pulse_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_valid_i && beat_last_i) |=> !res_valid_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_valid_i && beat_last_i) |=> ($stable(res_o) && $stable(nz_cnt_o)));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_last_i) |=> (acc_q == '0 && nz_row_q == '0));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_i |=> ($stable(acc_q) && $stable(nz_row_q)));

  p_nz_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nz_row_q <= NZ_W'(MAX_LEN));
endmodule

// File: rtl/ternary_dot.sv
module ternary_dot
  import ternary_pkg::*;
#(
  parameter int ACT_W   = 8,
  parameter int LANES   = 8,
  parameter int MAX_LEN = 256,
  localparam int LVL    = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int LANE_W = ACT_W + 1,
  localparam int SUM_W  = LANE_W + LVL,
  localparam int ACC_W  = ACT_W + $clog2(MAX_LEN) + 1,
  localparam int BNZ_W  = $clog2(LANES + 1),
  localparam int NZ_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic                   in_last_i,
  input  logic [LANES*ACT_W-1:0] act_i,
  input  logic [2*LANES-1:0]     wgt_i,
  output logic                   res_valid_o,
  output logic [ACC_W-1:0]       res_o,
  output logic [NZ_W-1:0]        nz_cnt_o
);
  logic [LANES*LANE_W-1:0] contrib;
  logic [LANES-1:0]        lane_nz;
  logic [SUM_W-1:0]        tree_sum;
  logic [BNZ_W-1:0]        beat_nz;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ternary_lane #(.ACT_W(ACT_W)) u_lane (
      .act_i     (act_i[i*ACT_W +: ACT_W]),
      .code_i    (wgt_i[2*i +: 2]),
      .contrib_o (contrib[i*LANE_W +: LANE_W]),
      .nz_o      (lane_nz[i])
    );
  end

  ternary_tree #(.LANES(LANES), .IN_W(LANE_W)) u_tree (
    .leaf_i (contrib),
    .sum_o  (tree_sum)
  );

  always_comb begin
    beat_nz = '0;
    for (int i = 0; i < LANES; i++) beat_nz = beat_nz + BNZ_W'(lane_nz[i]);
  end

  ternary_acc #(
    .SUM_W(SUM_W), .ACC_W(ACC_W), .BNZ_W(BNZ_W), .NZ_W(NZ_W), .MAX_LEN(MAX_LEN)
  ) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_valid_i (in_valid_i),
    .beat_last_i  (in_last_i),
    .beat_sum_i   (tree_sum),
    .beat_nz_i    (beat_nz),
    .res_valid_o  (res_valid_o),
    .res_o        (res_o),
    .nz_cnt_o     (nz_cnt_o)
  );

  // gated lanes must leave the tree sum at zero
  p_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && beat_nz == '0) |-> (tree_sum == '0));

  p_nz_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_nz) == int'(beat_nz));
endmodule

// File: tb/ternary_dot_tb.sv
`timescale 1ns/1ps
module ternary_dot_tb;
  localparam int ACT_W = 8;
  localparam int LANES = 8;
  localparam int MAX_LEN = 256;
  localparam int ACC_W = ACT_W + $clog2(MAX_LEN) + 1;
  localparam int NZ_W = $clog2(MAX_LEN + 1);
  localparam int AW = LANES * ACT_W;
  localparam int WW = 2 * LANES;

  // {weights, activations}, one single-beat row each
  localparam logic [WW+AW-1:0] VEC [6] = '{
    {16'h5555, 64'h0102030405060708},
    {16'hFFFF, 64'h0102030405060708},
    {16'h0000, 64'h7F7F7F7F7F7F7F7F},
    {16'hAAAA, 64'h8080808080808080},
    {16'hD274, 64'h807F05FB10F001FF},
    {16'h5555, 64'h8080808080808080}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [AW-1:0] act = '0;
  logic [WW-1:0] wgt = '0;
  logic res_valid;
  logic [ACC_W-1:0] res;
  logic [NZ_W-1:0] nz_cnt;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ternary_dot #(.ACT_W(ACT_W), .LANES(LANES), .MAX_LEN(MAX_LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_last_i(in_last),
    .act_i(act), .wgt_i(wgt), .res_valid_o(res_valid), .res_o(res), .nz_cnt_o(nz_cnt)
  );

  function automatic int ref_dot(input logic [AW-1:0] a, input logic [WW-1:0] w);
    int s = 0;
    for (int i = 0; i < LANES; i++) begin
      int av = int'($signed(a[i*ACT_W +: ACT_W]));
      int wv = (w[2*i +: 2] == 2'b01) ? 1 : (w[2*i +: 2] == 2'b11) ? -1 : 0;
      s += av * wv;
    end
    return s;
  endfunction

  function automatic int ref_nz(input logic [WW-1:0] w);
    int c = 0;
    for (int i = 0; i < LANES; i++)
      if (w[2*i +: 2] == 2'b01 || w[2*i +: 2] == 2'b11) c++;
    return c;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // drive at negedge, accepted at posedge, returns at next negedge
  task automatic beat(input logic v, input logic [AW-1:0] a, input logic [WW-1:0] w,
                      input logic l);
    in_valid = v; act = a; wgt = w; in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic chk_res(input string tag, input int exp_s, input int exp_n);
    chk(res_valid === 1'b1, {tag, " valid"}, int'(res_valid), 1);
    chk(int'($signed(res)) == exp_s, {tag, " sum"}, int'($signed(res)), exp_s);
    chk(int'(nz_cnt) == exp_n, {tag, " nz"}, int'(nz_cnt), exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, n;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(res_valid === 1'b0, "R9 valid in reset", int'(res_valid), 0);
    chk(res === '0, "R9 res in reset", int'(res), 0);
    chk(nz_cnt === '0, "R9 nz in reset", int'(nz_cnt), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(res_valid === 1'b0, "R9 valid after reset", int'(res_valid), 0);

    // R1 add, R2 subtract, R3 skip codes, R7 count: table walk
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a = VEC[k][AW-1:0];
      logic [WW-1:0] w = VEC[k][WW+AW-1:AW];
      beat(1'b1, a, w, 1'b1);
      chk_res($sformatf("R1/R2/R3/R7 vec%0d", k), ref_dot(a, w), ref_nz(w));
      @(negedge clk);
      chk(res_valid === 1'b0, "R4 pulse one cycle", int'(res_valid), 0);
    end

    // R4 multi-beat with R8 idle beat carrying last
    s = 0; n = 0;
    beat(1'b1, VEC[4][AW-1:0], VEC[4][WW+AW-1:AW], 1'b0);
    s += ref_dot(VEC[4][AW-1:0], VEC[4][WW+AW-1:AW]); n += ref_nz(VEC[4][WW+AW-1:AW]);
    chk(res_valid === 1'b0, "R4 no result mid row", int'(res_valid), 0);
    beat(1'b0, 64'h7F7F7F7F7F7F7F7F, 16'h5555, 1'b1);
    chk(res_valid === 1'b0, "R8 idle last ignored", int'(res_valid), 0);
    beat(1'b1, VEC[0][AW-1:0], VEC[0][WW+AW-1:AW], 1'b0);
    s += 36; n += 8;
    beat(1'b1, VEC[1][AW-1:0], 16'hFF00, 1'b1);
    s += ref_dot(VEC[1][AW-1:0], 16'hFF00); n += 4;
    chk_res("R4/R8 multi-beat", s, n);
    @(negedge clk);
    chk(int'($signed(res)) == s, "R4 hold", int'($signed(res)), s);

    // R5 back-to-back closing beats
    beat(1'b1, VEC[0][AW-1:0], VEC[0][WW+AW-1:AW], 1'b1);
    chk_res("R5 first row", 36, 8);
    beat(1'b1, VEC[0][AW-1:0], VEC[1][WW+AW-1:AW], 1'b1);
    chk_res("R5 second row", -36, 8);

    // R6 extremes over MAX_LEN elements
    for (int b = 0; b < MAX_LEN / LANES; b++)
      beat(1'b1, {LANES{8'h80}}, {LANES{2'b11}}, b == MAX_LEN / LANES - 1);
    chk_res("R6 max positive", 32768, MAX_LEN);
    for (int b = 0; b < MAX_LEN / LANES; b++)
      beat(1'b1, {LANES{8'h80}}, {LANES{2'b01}}, b == MAX_LEN / LANES - 1);
    chk_res("R6 max negative", -32768, MAX_LEN);

    // R3 zero row over many beats
    for (int b = 0; b < 4; b++)
      beat(1'b1, {LANES{8'h80}}, (b % 2 == 0) ? 16'h0000 : 16'hAAAA, b == 3);
    chk_res("R3 all skip row", 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule